// File: doc/BRIEF.md
# Video Sync Word Detector

This block sits at the parallel input of a serial video transmitter. It registers one 10-bit video word on each rising edge of the parallel clock. It watches for the reserved timing-reference values that open every sync word.

A word counts as reserved when its eight upper bits are all equal. In that case the block overwrites the two least significant bits with the same value. An 8-bit source and a 10-bit source then leave the block with identical codes: 000 or 3FF. A match also starts an active-low indication that lasts three clocks.

A disable input switches detection off so that arbitrary non-video data passes through unchanged. The disable is sampled together with the word it applies to. Each word reaches the output two clock edges after it is presented: one edge for the input latch and one for the output register.

Top module: `syncWordDetect`

## Requirements
- R1: A synchronous active-high reset drives dataOut to 0 and syncN high. The first word presented after reset is released is processed normally.
- R2: A word presented before rising edge N appears on dataOut after rising edge N+1. If its bits 9:2 are not all equal, it appears unchanged.
- R3: If bits 9:2 of an accepted word are all 0, dataOut carries bits 9:2 unchanged and bits 1:0 forced to 0.
- R4: If bits 9:2 of an accepted word are all 1, dataOut carries bits 9:2 unchanged and bits 1:0 forced to 1.
- R5: syncN is low for exactly three consecutive clock periods. The low period starts in the same period in which the matching word appears on dataOut. Otherwise syncN is high.
- R6: A match that arrives while syncN is already low restarts the three-period count from that word. It does not produce a separate pulse.
- R7: While syncDisable is high in the cycle a word is captured, that word passes unmodified and starts no low period. A low period that is already running still completes.
- R8: A word whose upper eight bits are mixed passes unchanged and leaves syncN untouched. Examples are 004 and 3FB, whose low bits alone would look reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 10 | Parallel video word, bit 0 least significant |
| syncDisable | input | 1 | High turns detection off for the word captured with it |
| dataOut | output | 10 | Registered, normalised video word |
| syncN | output | 1 | Active-low sync indication, three clocks long |

## Verification
The bound checker compares every cycle's dataOut against the word presented two edges earlier. It checks pass-through, forcing to zeros, forcing to ones and the disabled case. It also compares syncN against a history of the last three accepted matches, which covers the three-period width and the restart on a new match. The bench scenarios are needed for what that history cannot show on its own. These are reset arriving mid-pulse, a disabled word arriving while a pulse runs, near-miss codes such as 004 and 3FB, and back-to-back reserved words.

// File: rtl/syncWordPkg.sv
package syncWordPkg;
  // Strobes from control to datapath, one set per captured word
  typedef struct packed {
    logic forceZero;
    logic forceOne;
  } syncStrobe_t;
endpackage

// File: rtl/syncWordDatapath.sv
module syncWordDatapath
  import syncWordPkg::*;
#(
  parameter int DATA_W = 10,
  parameter int LOW_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              syncDisable,
  input  syncStrobe_t       strobe,
  output logic [DATA_W-LOW_BITS-1:0] upperBits,
  output logic              latchedDis,
  output logic              latchedValid,
  output logic [DATA_W-1:0] dataOut
);
  localparam int UPPER_W = DATA_W - LOW_BITS;

  logic [DATA_W-1:0] latchedWord;
  logic [DATA_W-1:0] normWord;

  // Input latch stage: word, disable and a valid flag captured together
  always_ff @(posedge clk) begin
    if (rst) begin
      latchedWord  <= '0;
      latchedDis   <= 1'b0;
      latchedValid <= 1'b0;
    end else begin
      latchedWord  <= dataIn;
      latchedDis   <= syncDisable;
      latchedValid <= 1'b1;
    end
  end

  assign upperBits = latchedWord[DATA_W-1:LOW_BITS];
  assign normWord[DATA_W-1:LOW_BITS] = latchedWord[DATA_W-1:LOW_BITS];

  // Per-bit override of the low bits
  for (genvar g = 0; g < LOW_BITS; g++) begin : gLowForce
    always_comb begin
      if (strobe.forceOne)       normWord[g] = 1'b1;
      else if (strobe.forceZero) normWord[g] = 1'b0;
      else                       normWord[g] = latchedWord[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dataOut <= '0;
    else     dataOut <= normWord;
  end

  logic [UPPER_W-1:0] unusedWidthTie;
  assign unusedWidthTie = upperBits;
endmodule

// File: rtl/syncWordControl.sv
module syncWordControl
  import syncWordPkg::*;
#(
  parameter int UPPER_W = 8,
  parameter int PULSE_LEN = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [UPPER_W-1:0] upperBits,
  input  logic               latchedDis,
  input  logic               latchedValid,
  output syncStrobe_t        strobe,
  output logic               syncN
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);

  logic active;
  logic hit;
  logic [CNT_W-1:0] pulseCnt;

  assign active = latchedValid & ~latchedDis;
  assign strobe.forceZero = active & ~(|upperBits);
  assign strobe.forceOne  = active & (&upperBits);
  assign hit = strobe.forceZero | strobe.forceOne;

  // Retriggerable down-counter: a new hit reloads the full length
  always_ff @(posedge clk) begin
    if (rst)                   pulseCnt <= '0;
    else if (hit)              pulseCnt <= CNT_LOAD;
    else if (pulseCnt != '0)   pulseCnt <= pulseCnt - 1'b1;
  end

  assign syncN = (pulseCnt == '0);
endmodule

// File: rtl/syncWordDetect.sv
module syncWordDetect
  import syncWordPkg::*;
#(
  parameter int DATA_W = 10,
  parameter int LOW_BITS = 2,
  parameter int PULSE_LEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              syncDisable,
  output logic [DATA_W-1:0] dataOut,
  output logic              syncN
);
  localparam int UPPER_W = DATA_W - LOW_BITS;

  syncStrobe_t        strobe;
  logic [UPPER_W-1:0] upperBits;
  logic               latchedDis;
  logic               latchedValid;

  syncWordDatapath #(.DATA_W(DATA_W), .LOW_BITS(LOW_BITS)) uDatapath (
    .clk(clk), .rst(rst), .dataIn(dataIn), .syncDisable(syncDisable),
    .strobe(strobe), .upperBits(upperBits), .latchedDis(latchedDis),
    .latchedValid(latchedValid), .dataOut(dataOut)
  );

  syncWordControl #(.UPPER_W(UPPER_W), .PULSE_LEN(PULSE_LEN)) uControl (
    .clk(clk), .rst(rst), .upperBits(upperBits), .latchedDis(latchedDis),
    .latchedValid(latchedValid), .strobe(strobe), .syncN(syncN)
  );
endmodule

// File: rtl/syncWordChecker.sv
module syncWordChecker #(
  parameter int DATA_W = 10,
  parameter int LOW_BITS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] dataIn,
  input logic              syncDisable,
  input logic [DATA_W-1:0] dataOut,
  input logic              syncN
);
  logic [1:0] sinceRst;
  logic       h1, h2, h3, h4;
  logic       inAllZero, inAllOne;

  assign inAllZero = ~(|dataIn[DATA_W-1:LOW_BITS]);
  assign inAllOne  = &dataIn[DATA_W-1:LOW_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceRst <= '0;
      {h1, h2, h3, h4} <= '0;
    end else begin
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 1'b1;
      h1 <= (inAllZero | inAllOne) & ~syncDisable;
      h2 <= h1;
      h3 <= h2;
      h4 <= h3;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (dataOut == '0 && syncN));

  assert_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2 && !$past(syncDisable, 2) &&
     ~(&$past(dataIn[DATA_W-1:LOW_BITS], 2)) && (|$past(dataIn[DATA_W-1:LOW_BITS], 2)))
    |-> dataOut == $past(dataIn, 2));

  assert_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2 && !$past(syncDisable, 2) && $past(inAllZero, 2))
    |-> dataOut == '0);

  assert_ones_R4: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2 && !$past(syncDisable, 2) && $past(inAllOne, 2))
    |-> dataOut == '1);

  // Three-period low window, restarted by every new match (R6)
  assert_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    syncN == !(h2 | h3 | h4));

  assert_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2 && $past(syncDisable, 2)) |-> dataOut == $past(dataIn, 2));
endmodule

bind syncWordDetect syncWordChecker #(.DATA_W(DATA_W), .LOW_BITS(LOW_BITS)) uChecker (
  .clk(clk), .rst(rst), .dataIn(dataIn), .syncDisable(syncDisable),
  .dataOut(dataOut), .syncN(syncN)
);

// File: tb/tb_syncWordDetect.sv
module tb_syncWordDetect;
  localparam int CYC = 5;
  localparam int NVEC = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] dataIn = 10'h155;
  logic       syncDisable = 1'b0;
  logic [9:0] dataOut;
  logic       syncN;
  int passCnt = 0;
  int totalCnt = 0;
  bit done = 1'b0;

  always #(CYC / 2.0) clk = ~clk;

  syncWordDetect dut (
    .clk(clk), .rst(rst), .dataIn(dataIn), .syncDisable(syncDisable),
    .dataOut(dataOut), .syncN(syncN)
  );

  // {disable, word in, expected word out, expected syncN}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0, 10'h155, 10'h155, 1'b1},  // R2
    {1'b0, 10'h2AA, 10'h2AA, 1'b1},  // R2
    {1'b0, 10'h002, 10'h000, 1'b0},  // R3, R5 start
    {1'b0, 10'h155, 10'h155, 1'b0},  // R5
    {1'b0, 10'h155, 10'h155, 1'b0},  // R5
    {1'b0, 10'h155, 10'h155, 1'b1},  // R5 end
    {1'b0, 10'h3FD, 10'h3FF, 1'b0},  // R4
    {1'b0, 10'h155, 10'h155, 1'b0},
    {1'b0, 10'h3FC, 10'h3FF, 1'b0},  // R6 restart
    {1'b0, 10'h155, 10'h155, 1'b0},  // R6
    {1'b0, 10'h155, 10'h155, 1'b0},  // R6
    {1'b0, 10'h155, 10'h155, 1'b1},  // R6
    {1'b1, 10'h001, 10'h001, 1'b1},  // R7
    {1'b1, 10'h3FE, 10'h3FE, 1'b1},  // R7
    {1'b0, 10'h004, 10'h004, 1'b1},  // R8
    {1'b0, 10'h3FB, 10'h3FB, 1'b1},  // R8
    {1'b0, 10'h000, 10'h000, 1'b0},  // R3
    {1'b1, 10'h3FE, 10'h3FE, 1'b0},  // R7 pulse keeps running
    {1'b0, 10'h203, 10'h203, 1'b0},  // R8
    {1'b0, 10'h1FF, 10'h1FF, 1'b1}   // R8
  };

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
  endtask

  task automatic drive(input logic d, input logic [9:0] w);
    syncDisable = d;
    dataIn = w;
  endtask

  initial begin
    #(CYC * 5000);
    if (!done) begin
      totalCnt++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check(dataOut == 10'h000, "R1 dataOut", dataOut, 0);
    check(syncN == 1'b1, "R1 syncN", syncN, 1);
    drive(1'b0, VEC[0][20:11]);
    rst = 1'b0;

    // Table walk: word i driven at negedge i, checked at negedge i+2
    for (int i = 1; i < NVEC + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check(dataOut == VEC[i-2][10:1], "R2/R3/R4 dataOut", dataOut, VEC[i-2][10:1]);
        check(syncN == VEC[i-2][0], "R5/R6 syncN", syncN, VEC[i-2][0]);
      end
      if (i < NVEC) drive(VEC[i][21], VEC[i][20:11]);
      else drive(1'b0, 10'h155);
    end

    // R6: back-to-back reserved words hold syncN low three periods after the last
    drive(1'b0, 10'h000); @(negedge clk);
    drive(1'b0, 10'h3FF); @(negedge clk);
    drive(1'b0, 10'h000); @(negedge clk);
    drive(1'b0, 10'h155);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(syncN == (k == 3), "R6 back-to-back", syncN, k == 3);
    end

    // R1: reset in the middle of a pulse
    drive(1'b0, 10'h3FF); @(negedge clk);
    drive(1'b0, 10'h155); @(negedge clk);
    check(syncN == 1'b0 && dataOut == 10'h3FF, "R4 before reset", {syncN, dataOut}, 10'h3FF);
    rst = 1'b1; @(negedge clk);
    check(dataOut == 10'h000, "R1 mid-pulse dataOut", dataOut, 0);
    check(syncN == 1'b1, "R1 mid-pulse syncN", syncN, 1);
    rst = 1'b0;
    drive(1'b0, 10'h003); @(negedge clk);
    drive(1'b0, 10'h155); @(negedge clk);
    // R1/R3: first word after reset processed normally
    check(dataOut == 10'h000, "R1 first word", dataOut, 0);
    check(syncN == 1'b0, "R1 first word syncN", syncN, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end
endmodule